// File: doc/BRIEF.md
# Dual-Channel Transmit Staging Buffer

This block holds outgoing bytes for two independent transmit channels until the host tells a channel to go. The host writes 32-bit words through a simple register port. A channel-select register decides which channel's byte buffer a data write lands in. Each channel has its own length register and its own start register. Once a channel is started, its bytes leave on one shared byte stream that uses a valid/ready handshake and marks the final byte.

After a channel's bytes have gone out, the channel is emptied, its length returns to zero, and its completion bit is set in a shared status register. A maskable interrupt line reports any status bit whose enable bit is set. Two error conditions are also recorded in the status register. One is a data word that does not fit in the buffer. The other is a start whose programmed length is larger than the number of bytes actually stored.

Register map (write port `reg_waddr`, read port `reg_raddr`):

| Addr | Meaning |
|------|---------|
| 0 | control: bit0 transmit enable; bit1 (write-only) clears both channels |
| 1 | channel select |
| 2 | data word (write-only) |
| 3 / 4 | length of channel 0 / 1 |
| 5 / 6 | start channel 0 / 1 (bit0) |
| 7 | interrupt enable |
| 8 | status (write 1 to clear) |

Status and enable bits: bit0 is channel 0 done, bit1 is channel 1 done, bit2 is overrun, bit3 is short length.

Top module: `dual_tx_stager`

## Requirements
- R1: A write to the channel-select register (addr 1) stores 0 or 1 as written. Any value of 2 or more selects channel 0. Reading addr 1 returns the stored selection.
- R2: A length write (addr 3 or 4) larger than DEPTH (default 64) stores DEPTH. Any other value is stored unchanged and reads back as written.
- R3: A data write (addr 2) appends the word to the selected channel as four bytes, bits 7:0 first and bits 31:24 last. The bytes leave on `tx_data` in the order stored, with `tx_chan` giving the channel.
- R4: A data write to a channel that has fewer than 4 free bytes is dropped, and status bit2 is set. The bytes already stored are unaffected.
- R5: A start write with bit0 set starts a channel only while the control enable bit (addr 0 bit0) is 1. Otherwise it has no effect: no bytes are sent, no status is set, and the length and data are kept.
- R6: The number of bytes sent is the lower of the programmed length and the bytes stored. When the length exceeds the stored count, status bit3 is set.
- R7: When a channel's send ends, that channel's length reads 0 and its buffer is empty, so a later start sends zero bytes. Its done bit (bit0 for channel 0, bit1 for channel 1) is set. A zero-byte send still sets the done bit.
- R8: `irq` is high exactly when some status bit and its enable bit (addr 7) are both 1. Writing 1s to the status register clears those bits and leaves the others alone.
- R9: A control write with bit1 set empties both channels and zeroes both lengths. The same write loads the enable bit from bit0.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_last` and `tx_chan` hold their values. `tx_last` is high only on the final byte of a send.
- R11: While a channel is waiting or sending, starts, data writes and length writes aimed at it are ignored. They change neither the bytes sent nor the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Downstream accepts byte |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a send |
| tx_chan | output | 1 | Channel the current byte belongs to |
| irq | output | 1 | Masked interrupt |

## Verification
The stream-hold property assumes that the host does not pulse the channel-clear bit while a byte is stalled. That clear aborts a send on purpose, so the stimulus issues it only when the stream is idle. The properties also assume that the register port carries one write per cycle, which means the two channels can never be started in the same cycle. The host-side tasks in the stimulus serialise every access to respect this. Apart from one deliberate case, the stimulus starts a channel only after the previous send has drained. That case is a stalled-stream sequence that exercises the ignored writes to a busy channel.

// File: rtl/dts_pkg.sv
package dts_pkg;
  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_CHSEL = 4'd1;
  localparam logic [3:0] A_DATA  = 4'd2;
  localparam logic [3:0] A_LEN0  = 4'd3;
  localparam logic [3:0] A_GO0   = 4'd5;
  localparam logic [3:0] A_IEN   = 4'd7;
  localparam logic [3:0] A_IST   = 4'd8;

  localparam int NCH = 2;
  localparam int NST = 4;
  localparam int ST_OVR   = 2;
  localparam int ST_SHORT = 3;

  // Clamp a requested length to the buffer capacity.
  function automatic logic [31:0] clamp_len(input logic [31:0] v, input logic [31:0] cap);
    return (v > cap) ? cap : v;
  endfunction

  // Bytes actually sendable: the smaller of wanted and held.
  function automatic logic [31:0] sendable(input logic [31:0] want, input logic [31:0] have);
    return (want > have) ? have : want;
  endfunction
endpackage

// File: rtl/dts_lane.sv
module dts_lane #(
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push_en,
  input  logic [31:0]   push_word,
  input  logic          len_we,
  input  logic [31:0]   len_val,
  input  logic          go,
  input  logic          tx_en,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_byte,
  output logic          busy,
  output logic [LW-1:0] send_len,
  output logic [LW-1:0] len_q,
  output logic          ovr_evt,
  output logic          short_evt
);
  import dts_pkg::*;

  localparam logic [31:0] CAP = 32'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [LW-1:0] fill_q;
  logic [LW-1:0] len_r;
  logic [LW-1:0] slen_q;
  logic          busy_q;

  logic [31:0] fill_w, free_w, len_clamped, take_w;
  logic        push_ok, go_ok;

  assign fill_w      = 32'(fill_q);
  assign free_w      = CAP - fill_w;
  assign len_clamped = clamp_len(len_val, CAP);
  assign take_w      = sendable(32'(len_r), fill_w);

  assign push_ok   = push_en && !busy_q && (free_w >= 32'd4);
  assign ovr_evt   = push_en && !busy_q && (free_w < 32'd4);
  assign go_ok     = go && tx_en && !busy_q;
  assign short_evt = go_ok && (32'(len_r) > fill_w);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      fill_q <= '0;
      len_r  <= '0;
      slen_q <= '0;
      busy_q <= 1'b0;
    end else begin
      if (push_ok) fill_q <= fill_q + LW'(4);
      if (len_we && !busy_q) len_r <= len_clamped[LW-1:0];
      if (go_ok) begin
        busy_q <= 1'b1;
        slen_q <= take_w[LW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) begin
      for (int k = 0; k < 4; k++) begin
        mem[fill_q[IW-1:0] + IW'(k)] <= push_word[8*k +: 8];
      end
    end
  end

  assign rd_byte  = mem[rd_idx];
  assign busy     = busy_q;
  assign send_len = slen_q;
  assign len_q    = len_r;
endmodule

// File: rtl/dts_pump.sv
module dts_pump #(
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic [1:0]    busy,
  input  logic [LW-1:0] slen0,
  input  logic [LW-1:0] slen1,
  input  logic [7:0]    rd_byte,
  output logic [IW-1:0] rd_idx,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          out_chan,
  output logic          done,
  output logic          done_chan
);
  logic          active_q, chan_q;
  logic [LW-1:0] idx_q, rem_q;

  logic          pick_any, pick_ch;
  logic [LW-1:0] pick_len;
  logic          zero_done, last_take;

  // channel 0 has priority when both are waiting
  assign pick_any = |busy;
  assign pick_ch  = !busy[0];
  assign pick_len = pick_ch ? slen1 : slen0;

  assign zero_done = !active_q && pick_any && (pick_len == '0) && !abort;
  assign last_take = active_q && out_ready && (rem_q == LW'(1)) && !abort;
  assign done      = zero_done || last_take;
  assign done_chan = active_q ? chan_q : pick_ch;

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      active_q <= 1'b0;
      chan_q   <= 1'b0;
      idx_q    <= '0;
      rem_q    <= '0;
    end else if (!active_q) begin
      if (pick_any && (pick_len != '0)) begin
        active_q <= 1'b1;
        chan_q   <= pick_ch;
        idx_q    <= '0;
        rem_q    <= pick_len;
      end
    end else if (out_ready) begin
      idx_q <= idx_q + LW'(1);
      rem_q <= rem_q - LW'(1);
      if (rem_q == LW'(1)) active_q <= 1'b0;
    end
  end

  assign rd_idx    = idx_q[IW-1:0];
  assign out_valid = active_q;
  assign out_data  = rd_byte;
  assign out_last  = active_q && (rem_q == LW'(1));
  assign out_chan  = chan_q;
endmodule

// File: rtl/dual_tx_stager.sv
module dual_tx_stager #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_waddr,
  input  logic [31:0] reg_wdata,
  input  logic [3:0]  reg_raddr,
  output logic [31:0] reg_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        tx_chan,
  output logic        irq
);
  import dts_pkg::*;

  localparam int IW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic           tx_en_q, chsel_q;
  logic [NST-1:0] ien_q, ist_q, ist_set, ist_clr;
  logic           gc_rst, data_we;
  logic [1:0]     busy_v, ovr_v, short_v;
  logic [LW-1:0]  slen_a [NCH];
  logic [LW-1:0]  len_a  [NCH];
  logic [7:0]     byte_a [NCH];
  logic [IW-1:0]  rd_idx;
  logic           done_evt, done_ch, cur_ch;

  assign gc_rst  = reg_we && (reg_waddr == A_CTRL) && reg_wdata[1];
  assign data_we = reg_we && (reg_waddr == A_DATA);

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    localparam logic [3:0] LEN_A = A_LEN0 + 4'(c);
    localparam logic [3:0] GO_A  = A_GO0 + 4'(c);
    dts_lane #(.DEPTH(DEPTH)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (gc_rst || (done_evt && (done_ch == 1'(c)))),
      .push_en   (data_we && (chsel_q == 1'(c))),
      .push_word (reg_wdata),
      .len_we    (reg_we && (reg_waddr == LEN_A)),
      .len_val   (reg_wdata),
      .go        (reg_we && (reg_waddr == GO_A) && reg_wdata[0]),
      .tx_en     (tx_en_q),
      .rd_idx    (rd_idx),
      .rd_byte   (byte_a[c]),
      .busy      (busy_v[c]),
      .send_len  (slen_a[c]),
      .len_q     (len_a[c]),
      .ovr_evt   (ovr_v[c]),
      .short_evt (short_v[c])
    );
  end

  dts_pump #(.DEPTH(DEPTH)) u_pump (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (gc_rst),
    .busy      (busy_v),
    .slen0     (slen_a[0]),
    .slen1     (slen_a[1]),
    .rd_byte   (byte_a[cur_ch]),
    .rd_idx    (rd_idx),
    .out_ready (tx_ready),
    .out_valid (tx_valid),
    .out_data  (tx_data),
    .out_last  (tx_last),
    .out_chan  (cur_ch),
    .done      (done_evt),
    .done_chan (done_ch)
  );
  assign tx_chan = cur_ch;

  assign ist_set = {|short_v, |ovr_v, done_evt && done_ch, done_evt && !done_ch};
  assign ist_clr = (reg_we && (reg_waddr == A_IST)) ? reg_wdata[NST-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en_q <= 1'b0;
      chsel_q <= 1'b0;
      ien_q   <= '0;
      ist_q   <= '0;
    end else begin
      if (reg_we && (reg_waddr == A_CTRL))  tx_en_q <= reg_wdata[0];
      if (reg_we && (reg_waddr == A_CHSEL)) chsel_q <= (reg_wdata < 32'd2) ? reg_wdata[0] : 1'b0;
      if (reg_we && (reg_waddr == A_IEN))   ien_q <= reg_wdata[NST-1:0];
      ist_q <= (ist_q & ~ist_clr) | ist_set;
    end
  end

  assign irq = |(ist_q & ien_q);

  always_comb begin
    case (reg_raddr)
      A_CTRL:      reg_rdata = 32'(tx_en_q);
      A_CHSEL:     reg_rdata = 32'(chsel_q);
      A_LEN0:      reg_rdata = 32'(len_a[0]);
      A_LEN0 + 4'd1: reg_rdata = 32'(len_a[1]);
      A_IEN:       reg_rdata = 32'(ien_q);
      A_IST:       reg_rdata = 32'(ist_q);
      default:     reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/dts_chk.sv
module dts_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_last,
  input logic       tx_chan,
  input logic [1:0] lane_busy,
  input logic       tx_en_q,
  input logic       done_evt,
  input logic       done_ch,
  input logic [3:0] ist_q,
  input logic       gc_rst
);
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !gc_rst |=> tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_chan));

  // R3
  owner_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> lane_busy[tx_chan]);

  // R5
  gate_en0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane_busy[0]) |-> $past(tx_en_q));

  // R5
  gate_en1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane_busy[1]) |-> $past(tx_en_q));

  // R7
  free0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && !done_ch |=> !lane_busy[0] && ist_q[0]);

  // R7
  free1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && done_ch |=> !lane_busy[1] && ist_q[1]);
endmodule

bind dual_tx_stager dts_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .tx_last   (tx_last),
  .tx_chan   (tx_chan),
  .lane_busy (busy_v),
  .tx_en_q   (tx_en_q),
  .done_evt  (done_evt),
  .done_ch   (done_ch),
  .ist_q     (ist_q),
  .gc_rst    (gc_rst)
);

// File: tb/tb_dual_tx_stager.sv
module tb_dual_tx_stager;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        tx_valid, tx_last, tx_chan, irq;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;

  always #2 clk = ~clk;

  dual_tx_stager #(.DEPTH(DEPTH)) dut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;
  bit hold = 0;
  int rdy_cnt = 0;

  logic [9:0] sbq [$];
  logic [7:0] mq0 [$];
  logic [7:0] mq1 [$];
  int  m_len [2];
  bit  m_en = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_raddr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic push(input int ch, input logic [31:0] w);
    int sz;
    sz = (ch == 0) ? mq0.size() : mq1.size();
    if (sz + 4 <= DEPTH) begin
      for (int k = 0; k < 4; k++) begin
        if (ch == 0) mq0.push_back(w[8*k +: 8]);
        else         mq1.push_back(w[8*k +: 8]);
      end
    end
    wr(4'd2, w);
  endtask

  task automatic set_len(input int ch, input int v);
    m_len[ch] = (v > DEPTH) ? DEPTH : v;
    wr(4'(3 + ch), 32'(v));
  endtask

  task automatic go(input int ch);
    int have, n;
    if (m_en) begin
      have = (ch == 0) ? mq0.size() : mq1.size();
      n = (m_len[ch] > have) ? have : m_len[ch];
      for (int i = 0; i < n; i++) begin
        logic [7:0] b;
        b = (ch == 0) ? mq0[i] : mq1[i];
        sbq.push_back({1'(ch), (i == n - 1), b});
      end
      if (ch == 0) mq0.delete(); else mq1.delete();
      m_len[ch] = 0;
    end
    wr(4'(5 + ch), 32'd1);
  endtask

  task automatic wait_idle();
    int t;
    t = 0;
    while (sbq.size() != 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (6) @(negedge clk);
  endtask

  // monitor: sets ready for the coming edge, then scores the byte that edge takes
  always @(negedge clk) begin
    rdy_cnt++;
    tx_ready = hold ? 1'b0 : ((rdy_cnt % 3) != 1);
    if (rst_n && tx_valid && tx_ready) begin
      n_cmp++;
      if (sbq.size() == 0) begin
        n_bad++;
        $display("FAIL R3/R5 unexpected byte actual=%h expected=none", tx_data);
      end else begin
        logic [9:0] e;
        e = sbq.pop_front();
        if ({tx_chan, tx_last, tx_data} !== e) begin
          n_bad++;
          $display("FAIL R3/R6/R10 byte actual=%h expected=%h", {tx_chan, tx_last, tx_data}, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd_chk("reset status", 4'd8, 32'h0);
    rd_chk("reset len0", 4'd3, 32'h0);
    rd_chk("reset chsel", 4'd1, 32'h0);
    check("reset irq", 32'(irq), 32'h0);
    check("reset tx_valid", 32'(tx_valid), 32'h0);

    // R1 channel select
    wr(4'd1, 32'd1); rd_chk("R1 sel=1", 4'd1, 32'd1);
    wr(4'd1, 32'd7); rd_chk("R1 sel=7->0", 4'd1, 32'd0);
    wr(4'd1, 32'd1); wr(4'd1, 32'd2); rd_chk("R1 sel=2->0", 4'd1, 32'd0);

    // R2 length clamp
    set_len(0, 200); rd_chk("R2 clamp 200", 4'd3, 32'd64);
    set_len(0, 64);  rd_chk("R2 exact 64", 4'd3, 32'd64);
    set_len(1, 9);   rd_chk("R2 keep 9", 4'd4, 32'd9);
    set_len(0, 0); set_len(1, 0);

    // R5 start blocked while disabled
    push(0, 32'h44332211); push(0, 32'h88776655);
    set_len(0, 8);
    go(0);
    repeat (20) @(negedge clk);
    rd_chk("R5 no status", 4'd8, 32'h0);
    rd_chk("R5 len kept", 4'd3, 32'd8);
    // R3 enabled send, byte order low first
    wr(4'd0, 32'd1); m_en = 1;
    go(0);
    wait_idle();
    rd_chk("R7 done0", 4'd8, 32'h1);
    rd_chk("R7 len0 zero", 4'd3, 32'd0);

    // R8 interrupt masking and clear
    check("R8 irq masked", 32'(irq), 32'd0);
    wr(4'd7, 32'h1);
    @(negedge clk); check("R8 irq on", 32'(irq), 32'd1);
    wr(4'd8, 32'h2);
    rd_chk("R8 w1c other", 4'd8, 32'h1);
    check("R8 irq still", 32'(irq), 32'd1);
    wr(4'd8, 32'h1);
    rd_chk("R8 w1c own", 4'd8, 32'h0);
    check("R8 irq off", 32'(irq), 32'd0);

    // R7 restart after clear sends nothing
    go(0);
    wait_idle();
    rd_chk("R7 zero send done", 4'd8, 32'h1);
    wr(4'd8, 32'hF);

    // R6 length exact and short
    wr(4'd1, 32'd1);
    push(1, 32'hA3A2A1A0); push(1, 32'hA7A6A5A4); push(1, 32'hABAAA9A8);
    set_len(1, 10);
    go(1);
    wait_idle();
    rd_chk("R6 no short", 4'd8, 32'h2);
    wr(4'd8, 32'hF);
    push(1, 32'hB3B2B1B0); push(1, 32'hB7B6B5B4);
    set_len(1, 20);
    go(1);
    wait_idle();
    rd_chk("R6 short flag", 4'd8, 32'hA);
    check("R8 irq masked short", 32'(irq), 32'd0);
    wr(4'd7, 32'h8);
    @(negedge clk); check("R8 irq short", 32'(irq), 32'd1);
    wr(4'd8, 32'hF);
    wr(4'd7, 32'h0);

    // R4 overrun
    wr(4'd1, 32'd0);
    for (int i = 0; i < 16; i++) push(0, 32'h03020100 + 32'h04040404 * 32'(i));
    rd_chk("R4 full no flag", 4'd8, 32'h0);
    push(0, 32'hDEADBEEF);
    rd_chk("R4 overrun flag", 4'd8, 32'h4);
    set_len(0, 100);
    go(0);
    wait_idle();
    rd_chk("R4 sent 64 done", 4'd8, 32'h5);
    wr(4'd8, 32'hF);

    // R11 writes to a busy channel ignored; R10 hold while stalled
    wr(4'd1, 32'd1);
    push(1, 32'hC3C2C1C0); push(1, 32'hC7C6C5C4);
    set_len(1, 8);
    hold = 1;
    repeat (2) @(negedge clk);
    go(1);
    repeat (3) @(negedge clk);
    check("R10 valid while stalled", 32'(tx_valid), 32'd1);
    d0 = tx_data;
    wr(4'd6, 32'd1);
    wr(4'd2, 32'h12345678);
    wr(4'd4, 32'd3);
    check("R10 valid held", 32'(tx_valid), 32'd1);
    check("R10 data held", 32'(tx_data), 32'(d0));
    hold = 0;
    wait_idle();
    rd_chk("R11 len1 cleared", 4'd4, 32'd0);
    rd_chk("R11 status", 4'd8, 32'h2);
    wr(4'd8, 32'hF);
    go(1);
    wait_idle();
    rd_chk("R11 nothing kept", 4'd8, 32'h2);
    wr(4'd8, 32'hF);

    // R9 clear both channels
    wr(4'd1, 32'd0);
    push(0, 32'h55555555);
    set_len(0, 4);
    wr(4'd1, 32'd1);
    push(1, 32'h66666666);
    set_len(1, 4);
    wr(4'd0, 32'h3);
    mq0.delete(); mq1.delete(); m_len[0] = 0; m_len[1] = 0;
    rd_chk("R9 len0", 4'd3, 32'd0);
    rd_chk("R9 len1", 4'd4, 32'd0);
    rd_chk("R9 enable kept", 4'd0, 32'd1);
    go(0);
    go(1);
    wait_idle();
    rd_chk("R9 empty sends", 4'd8, 32'h3);
    wr(4'd8, 32'hF);
    wr(4'd0, 32'h0); m_en = 0;
    go(0);
    repeat (10) @(negedge clk);
    rd_chk("R9 disable via bit0", 4'd8, 32'h0);

    check("R3 scoreboard drained", 32'(sbq.size()), 32'd0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule